// File: doc/BRIEF.md
# I2C Slave Register Access Controller

This block is the slave-only serial front end of a small register bank. It watches the bus clock and data lines through a synchronizer clocked by the system clock, and finds START, repeated START and STOP conditions from edges in that clock domain. It answers one 7-bit bus identity. The upper five bits of that identity are fixed by a parameter. The two lower bits come from strap pins, so that up to four copies can share one bus.

After a matching identity byte with the direction bit clear, the first byte the master sends is the register address. If the master then sends one data byte, that byte is written to the bank with a single-cycle strobe. A read has three steps: the master writes the address, issues a repeated START, and sends the identity with the direction bit set. The slave then returns bytes, starting at that address, for as long as the master acknowledges each one.

SDA is driven open-drain. The block pulls the line low for its acknowledge bits and for data bits equal to 0, and releases it at all other times. Its output only changes after SCL has fallen. The register side is a plain synchronous port with address, write data, write strobe, read strobe and read data.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o`=0), no strobe is active, and the controller waits for a START.
- R2: An identity byte is accepted only when its bits [7:3] equal 01010 and its bits [2:1] equal `strap_i`[1:0]. Bit 0 is the direction: 1 means read, 0 means write. An accepted byte is acknowledged by pulling SDA low in the ninth clock. A rejected byte is not acknowledged, and every later byte is ignored until the next START.
- R3: The sequence START, identity (write), address byte, data byte writes the data to that address. Each of the three bytes is acknowledged, and `reg_we_o` is high for exactly one cycle, carrying the address on `reg_addr_o` and the data on `reg_wdata_o`.
- R4: In a write, a byte after the first data byte is not acknowledged and causes no further write strobe.
- R5: The sequence START, identity (write), address, repeated START, identity (read) is acknowledged at every byte. The slave then sends the register at that address, MSB first. Bits are sampled on SCL rising edges and SDA changes only after SCL falling edges.
- R6: During a read, an acknowledge from the master (SDA low in the ninth clock) makes the slave send the next byte from the address plus one. The address is 8 bits and wraps from 0xFF to 0x00. A NACK ends the read and leaves SDA released.
- R7: While `ready_i` is low, START conditions are ignored and SDA stays released.
- R8: A STOP returns the controller to standby. Later bytes are ignored until a START is seen.
- R9: `sda_oe_o` changes only while SCL is low.
- R10: `reg_we_o` and `reg_re_o` are single-cycle pulses and are never high together. `reg_rdata_i` is sampled in the cycle `reg_re_o` is high, and reflects `reg_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ready_i | input | 1 | Low while power-up is in progress; the bus is ignored while it is low |
| strap_i | input | 2 | Pin-strapped low identity bits |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | 8 | Register address pointer |
| reg_wdata_o | output | 8 | Write data to the bank |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data from the bank for `reg_addr_o` |

## Verification
The tests drive writes and reads with byte values that have both high and low bits, so the tests show whether bit order and the acknowledge timing are correct. Reads of one byte, of several bytes, and across the 0xFF-to-0x00 address wrap test the address increment and the way a NACK ends a read. Three kinds of identity byte are sent. A byte with a wrong prefix and a byte with the wrong strap bits test the match logic. A byte sent with other strap settings tests that the strap pins set the identity. The remaining tests send bytes after STOP, send extra write bytes, and send a START while not ready. These show whether the controller really leaves a transaction, rather than only failing to acknowledge.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    BS_IDLE,
    BS_ID,
    BS_ID_ACK,
    BS_ADDR,
    BS_ADDR_ACK,
    BS_WDAT,
    BS_WDAT_ACK,
    BS_TX,
    BS_MACK,
    BS_HOLD
  } bus_state_e;

endpackage

// File: rtl/i2c_reg_slave_sync.sv
module i2c_reg_slave_sync #(
  parameter int N_LINES = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] sync_o
);

  genvar ln;
  generate
    for (ln = 0; ln < N_LINES; ln++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], raw_i[ln]};
        end
      end
      assign sync_o[ln] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_reg_slave_cond.sv
module i2c_reg_slave_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // SDA edges only count as conditions while SCL is high in both samples.
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_reg_slave_ctrl.sv
module i2c_reg_slave_ctrl
  import i2c_reg_slave_pkg::*;
#(
  parameter int             STRAP_W = 2,
  parameter logic [6:0]     ID_BASE = 7'b0101000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_lvl,
  input  logic [BYTE_W-1:0]  reg_rdata_i,
  output logic               sda_oe_o,
  output logic [BYTE_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o
);

  localparam int         CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  bus_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rsh_q, rsh_d;
  logic [BYTE_W-1:0] tsh_q, tsh_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic              rd_q, rd_d;
  logic              mack_q, mack_d;
  logic              we_q, we_d;
  logic              re_q, re_d;
  logic              id_match;

  // Identity: fixed upper bits, strap-selected lower bits, direction in bit 0.
  assign id_match = (rsh_q[BYTE_W-1:STRAP_W+1] == ID_BASE[6:STRAP_W]) &&
                    (rsh_q[STRAP_W:1] == strap_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rsh_d   = rsh_q;
    tsh_d   = tsh_q;
    ptr_d   = ptr_q;
    wdat_d  = wdat_q;
    rd_d    = rd_q;
    mack_d  = mack_q;
    we_d    = 1'b0;
    re_d    = 1'b0;

    if (re_q) begin
      tsh_d = reg_rdata_i;
    end

    if (!ready_i) begin
      state_d = BS_IDLE;
    end else if (start_det) begin
      state_d = BS_ID;
      cnt_d   = '0;
    end else if (stop_det) begin
      state_d = BS_IDLE;
    end else begin
      unique case (state_q)
        BS_ID, BS_ADDR, BS_WDAT: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            rsh_d = {rsh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (state_q == BS_ID) begin
              if (id_match) begin
                state_d = BS_ID_ACK;
                rd_d    = rsh_q[0];
                re_d    = rsh_q[0];
              end else begin
                state_d = BS_HOLD;
              end
            end else if (state_q == BS_ADDR) begin
              ptr_d   = rsh_q;
              state_d = BS_ADDR_ACK;
            end else begin
              wdat_d  = rsh_q;
              we_d    = 1'b1;
              state_d = BS_WDAT_ACK;
            end
          end
        end
        BS_ID_ACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            state_d = rd_q ? BS_TX : BS_ADDR;
          end
        end
        BS_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            state_d = BS_WDAT;
          end
        end
        BS_WDAT_ACK: begin
          if (scl_fall) begin
            state_d = BS_HOLD;
          end
        end
        BS_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              state_d = BS_MACK;
              ptr_d   = ptr_q + 1'b1;
            end else begin
              tsh_d = {tsh_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        BS_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
            re_d   = ~sda_lvl;
          end else if (scl_fall) begin
            cnt_d   = '0;
            state_d = mack_q ? BS_TX : BS_HOLD;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      cnt_q   <= '0;
      rsh_q   <= '0;
      tsh_q   <= '0;
      ptr_q   <= '0;
      wdat_q  <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rsh_q   <= rsh_d;
      tsh_q   <= tsh_d;
      ptr_q   <= ptr_d;
      wdat_q  <= wdat_d;
      rd_q    <= rd_d;
      mack_q  <= mack_d;
      we_q    <= we_d;
      re_q    <= re_d;
    end
  end

  assign sda_oe_o    = (state_q == BS_ID_ACK) || (state_q == BS_ADDR_ACK) ||
                       (state_q == BS_WDAT_ACK) ||
                       ((state_q == BS_TX) && !tsh_q[BYTE_W-1]);
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdat_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_slave_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         STRAP_W     = 2,
  parameter logic [6:0] ID_BASE     = 7'b0101000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [BYTE_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  input  logic [BYTE_W-1:0]  reg_rdata_i
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic [1:0] line_s;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  i2c_reg_slave_sync #(
    .N_LINES (2),
    .STAGES  (SYNC_STAGES)
  ) sync_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .raw_i  ({scl_i, sda_i}),
    .sync_o (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_reg_slave_cond cond_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_reg_slave_ctrl #(
    .STRAP_W (STRAP_W),
    .ID_BASE (ID_BASE)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ready_i     (ready_i),
    .strap_i     (strap_i),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_lvl     (sda_s),
    .reg_rdata_i (reg_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o)
  );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ready_i,
  input logic scl_lvl,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic reg_re_o
);

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && $past(ready_i)) |-> !scl_lvl);

  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  // R10
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re_o |=> !reg_re_o);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o));

  // R7
  not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> (!sda_oe_o && !reg_we_o && !reg_re_o));

endmodule

bind i2c_reg_slave i2c_reg_slave_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready_i  (ready_i),
  .scl_lvl  (scl_s),
  .sda_oe_o (sda_oe_o),
  .reg_we_o (reg_we_o),
  .reg_re_o (reg_re_o)
);

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;

  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ready;
  logic [1:0] strap;
  logic       scl_m;
  logic       sda_m;
  logic       sda_oe;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic       reg_re;
  logic [7:0] reg_rdata;
  wire        sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  int         we_cnt;
  logic [7:0] last_wa;
  logic [7:0] last_wd;
  logic       prev_oe;
  int         oe_bad;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  i2c_reg_slave dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready),
    .strap_i     (strap),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_re_o    (reg_re),
    .reg_rdata_i (reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      we_cnt  <= 0;
      prev_oe <= 1'b0;
      oe_bad  <= 0;
    end else begin
      prev_oe <= sda_oe;
      if (sda_oe !== prev_oe && scl_m) oe_bad <= oe_bad + 1;
      if (reg_we) begin
        we_cnt       <= we_cnt + 1;
        last_wa      <= reg_addr;
        last_wd      <= reg_wdata;
        mem[reg_addr] <= reg_wdata;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_bus;  tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  function automatic logic [7:0] id_byte(input logic [1:0] s, input logic rd);
    return {5'b01010, s, rd};
  endfunction

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1", "sda released", sda_oe, 0);
    chk(reg_we == 1'b0 && reg_re == 1'b0, "R1", "no strobe", {reg_we, reg_re}, 0);
    chk(we_cnt == 0, "R1", "no writes", we_cnt, 0);
  endtask

  task automatic t_write(input logic [1:0] s, input logic [7:0] a, input logic [7:0] d);
    logic k0, k1, k2;
    int   n0 = we_cnt;
    bus_start();
    send_byte(id_byte(s, 1'b0), k0);
    send_byte(a, k1);
    send_byte(d, k2);
    bus_stop();
    tick(4);
    chk(k0 && k1 && k2, "R3", "three acks", {k0, k1, k2}, 3'b111);
    chk(we_cnt == n0 + 1, "R3", "one strobe", we_cnt, n0 + 1);
    chk(last_wa == a && last_wd == d, "R3", "addr/data", {last_wa, last_wd}, {a, d});
  endtask

  task automatic t_extra_byte();
    logic k0, k1, k2, k3;
    int   n0 = we_cnt;
    bus_start();
    send_byte(id_byte(2'b00, 1'b0), k0);
    send_byte(8'h20, k1);
    send_byte(8'h5A, k2);
    send_byte(8'hC3, k3);
    bus_stop();
    tick(4);
    chk(k2 && !k3, "R4", "extra byte nacked", {k2, k3}, 2'b10);
    chk(we_cnt == n0 + 1 && last_wd == 8'h5A, "R4", "single strobe", we_cnt, n0 + 1);
  endtask

  task automatic t_read(input logic [7:0] a, input int n);
    logic       k0, k1, k2;
    logic [7:0] v;
    logic [7:0] e;
    bus_start();
    send_byte(id_byte(2'b00, 1'b0), k0);
    send_byte(a, k1);
    bus_rstart();
    send_byte(id_byte(2'b00, 1'b1), k2);
    chk(k0 && k1 && k2, "R5", "read setup acks", {k0, k1, k2}, 3'b111);
    for (int i = 0; i < n; i++) begin
      e = mem[8'(a + i)];
      recv_byte(i != n - 1, v);
      chk(v == e, (i == 0) ? "R5" : "R6", "read byte", v, e);
    end
    chk(sda_oe == 1'b0, "R6", "released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_bad_id();
    logic k0, k1, k2;
    int   n0 = we_cnt;
    bus_start();
    send_byte(8'h58, k0);
    send_byte(8'h10, k1);
    send_byte(8'h99, k2);
    bus_stop();
    tick(4);
    chk(!k0 && !k1 && !k2, "R2", "bad prefix ignored", {k0, k1, k2}, 0);
    chk(we_cnt == n0, "R2", "no write on bad id", we_cnt, n0);
    bus_start();
    send_byte(id_byte(2'b01, 1'b0), k0);
    bus_stop();
    chk(!k0, "R2", "strap mismatch nacked", k0, 0);
  endtask

  task automatic t_not_ready();
    logic k0;
    ready = 1'b0;
    tick(4);
    bus_start();
    send_byte(id_byte(2'b00, 1'b0), k0);
    bus_stop();
    chk(!k0, "R7", "start ignored when not ready", k0, 0);
    ready = 1'b1;
    tick(4);
  endtask

  task automatic t_after_stop();
    logic k0, k1, k2;
    int   n0 = we_cnt;
    bus_start();
    send_byte(id_byte(2'b00, 1'b0), k0);
    bus_stop();
    scl_m = 1'b0; tick(Q);
    send_byte(id_byte(2'b00, 1'b0), k1);
    send_byte(8'h44, k2);
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    chk(k0 && !k1 && !k2, "R8", "bytes after stop ignored", {k0, k1, k2}, 3'b100);
    chk(we_cnt == n0, "R8", "no write after stop", we_cnt, n0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ready = 1'b1; strap = 2'b00; scl_m = 1'b1; sda_m = 1'b1;
    tick(10);
    rst_n = 1'b1;
    tick(10);
    t_reset();
    t_write(2'b00, 8'h12, 8'hA5);
    t_read(8'h12, 1);
    t_read(8'h30, 3);
    t_read(8'hFF, 2);
    t_extra_byte();
    t_bad_id();
    strap = 2'b11;
    tick(4);
    t_write(2'b11, 8'h40, 8'h3C);
    strap = 2'b00;
    tick(4);
    t_not_ready();
    t_write(2'b00, 8'h41, 8'h81);
    t_after_stop();
    chk(oe_bad == 0, "R9", "sda changes only with scl low", oe_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule